// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a clock-synchronous behavioural model of the command front end of a byte-wide parallel NOR flash, built over a small register array. A host issues bus write cycles (address, data, write strobe) and bus read cycles (address, read strobe). Writes are decoded as unlock-protected command sequences. The block accepts these commands: byte program, chip erase, sector erase, identification entry and identification exit. A sequence that deviates from the expected address/data step drops the interpreter back to plain read mode.

After a program or erase starts, the block stays busy for a parameterised number of clock cycles. For an erase it stays busy for at least as many cycles as the bytes it clears. While busy, reads return a status byte instead of array data, and every write is ignored. In identification mode, reads return a manufacturer byte or a device byte. The `busy` output exposes the internal write state so that a host or a testbench can wait on it directly.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: When a clock edge samples `rst_n` low, `busy` goes low, `rdata` becomes 0x00, and the interpreter returns to array read mode with identification mode off.
- R2: Four writes start a byte program: 0x5555/0xAA, then 0x2AAA/0x55, then 0x5555/0xA0, then the target address and data. Only `addr[14:0]` is compared against command addresses, and higher bits are ignored. The stored byte becomes the old byte AND the new data, so bits only ever clear.
- R3: Six writes start a chip erase: 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x10. Every byte becomes 0xFF, and `busy` stays high for max(ERASE_CYC, 2^ARR_W) cycles.
- R4: A sector erase uses the same five leading writes as R3, then any address with data 0x30. It sets to 0xFF every byte whose index bits [ARR_W-1:SECT_LSB] equal those of that address and leaves all other bytes unchanged. `busy` stays high for max(ERASE_CYC, 2^SECT_LSB) cycles.
- R5: `busy` rises on the clock edge that samples the fourth program write and stays high for exactly PROG_CYC cycles.
- R6: A write that does not match the expected step of a sequence returns the interpreter to idle. No program or erase starts from a broken sequence.
- R7: A read taken while busy returns a status byte. Bit 7 is the inverse of bit 7 of the data being programmed, or 0 during an erase. Bits 5:0 are 0.
- R8: Status bit 6 is 1 on the first read of a busy period and inverts on each further status read.
- R9: While busy, every write is ignored, including 0xF0, an unlock step and a program or erase step. Array contents and identification mode are unaffected.
- R10: The writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x90 enter identification mode. In that mode a read returns MFR_ID when `addr[0]` is 0 and DEV_ID when `addr[0]` is 1.
- R11: Identification mode ends in either of two ways: a single write of 0xF0 to any address while idle, or the three-write form ending 0x5555/0xF0. Reads then return array data again.
- R12: Outside busy and identification mode, a read returns the byte at index `addr[ARR_W-1:0]`. `rdata` updates on the clock edge that samples `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus address for reads and writes |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered read data: array byte, identification byte or status |
| busy | output | 1 | High while an internal program or erase is in progress |

## Verification
A wrong sequencer state shows on `busy` one cycle after the final write of a sequence. Either `busy` rises when it should not, or it stays low where a program or erase should have begun. Any data damage from that is visible in the next sweep over the array. A status path fault shows on the very first read of a busy period, because the first read must carry bit 6 set and the correct bit 7. A miscounted erase walker or busy timer shows as a `busy` period of the wrong length, and as bytes inside or outside the target sector holding the wrong value when the whole array is read back.

// File: rtl/nor_cmd_pkg.sv
// Shared command codes, unlock addresses and state types for the flash
// command interpreter. Assumes a command-address width of 15 bits.
package nor_cmd_pkg;
    localparam int          CMD_W     = 15;
    localparam logic [14:0] ULK_ADDR1 = 15'h5555;
    localparam logic [14:0] ULK_ADDR2 = 15'h2AAA;
    localparam logic [7:0]  ULK_KEY1  = 8'hAA;
    localparam logic [7:0]  ULK_KEY2  = 8'h55;
    localparam logic [7:0]  CMD_PGM   = 8'hA0;
    localparam logic [7:0]  CMD_ERS   = 8'h80;
    localparam logic [7:0]  CMD_IDENT = 8'h90;
    localparam logic [7:0]  CMD_LEAVE = 8'hF0;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_SECT  = 8'h30;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_K1, SQ_K2, SQ_PGM, SQ_E1, SQ_E2, SQ_E3
    } seq_t;

    typedef enum logic [1:0] {
        JOB_NONE, JOB_PROG, JOB_CHIP, JOB_SECT
    } job_t;
endpackage

// File: rtl/nor_seq_fsm.sv
// Command sequence decoder. Tracks the unlock handshake and emits a
// one-cycle job request (combinational, same cycle as the final write).
// Assumes the caller gates nothing: writes seen while busy_i is high are
// dropped here. Owns the identification-mode flag.
module nor_seq_fsm
    import nor_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             busy_i,
    input  logic [CMD_W-1:0] cmd_addr,
    input  logic [7:0]       wdata,
    output job_t             job_o,
    output logic             id_mode_o,
    output seq_t             state_o
);
    seq_t state_q, state_d;
    logic id_q, id_d;
    logic at_a1, at_a2;

    assign at_a1 = (cmd_addr == ULK_ADDR1);
    assign at_a2 = (cmd_addr == ULK_ADDR2);

    // Next-state, identification flag and job request for one bus write.
    always_comb begin
        state_d = state_q;
        id_d    = id_q;
        job_o   = JOB_NONE;
        if (wr_en && !busy_i) begin
            state_d = SQ_IDLE;
            if (state_q != SQ_PGM && wdata == CMD_LEAVE) begin
                id_d = 1'b0;
            end else begin
                unique case (state_q)
                    SQ_IDLE: if (at_a1 && wdata == ULK_KEY1) state_d = SQ_K1;
                    SQ_K1:   if (at_a2 && wdata == ULK_KEY2) state_d = SQ_K2;
                    SQ_K2: begin
                        if (at_a1) begin
                            if (wdata == CMD_PGM)        state_d = SQ_PGM;
                            else if (wdata == CMD_ERS)   state_d = SQ_E1;
                            else if (wdata == CMD_IDENT) id_d    = 1'b1;
                        end
                    end
                    SQ_PGM:  job_o = JOB_PROG;
                    SQ_E1:   if (at_a1 && wdata == ULK_KEY1) state_d = SQ_E2;
                    SQ_E2:   if (at_a2 && wdata == ULK_KEY2) state_d = SQ_E3;
                    SQ_E3: begin
                        if (at_a1 && wdata == CMD_CHIP)  job_o = JOB_CHIP;
                        else if (wdata == CMD_SECT)      job_o = JOB_SECT;
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    // State and identification flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            id_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            id_q    <= id_d;
        end
    end

    assign id_mode_o = id_q;
    assign state_o   = state_q;
endmodule

// File: rtl/nor_busy_timer.sv
// Down-counter that holds busy_o high for len_i cycles after start_i.
// Assumes start_i is only pulsed while the counter is idle.
module nor_busy_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             busy_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= len_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/nor_byte_array.sv
// Byte storage with program (AND into old content) and an erase walker
// that clears one byte per cycle over a chip or a sector. Assumes a
// program request never arrives while the walker is active.
module nor_byte_array #(
    parameter int ARR_W    = 10,
    parameter int SECT_LSB = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pgm_en,
    input  logic             chip_en,
    input  logic             sect_en,
    input  logic [ARR_W-1:0] job_idx,
    input  logic [7:0]       pgm_byte,
    input  logic [ARR_W-1:0] rd_idx,
    output logic [7:0]       rd_byte,
    output logic             walk_busy
);
    localparam int DEPTH     = 1 << ARR_W;
    localparam int SECT_SIZE = (SECT_LSB >= ARR_W) ? DEPTH : (1 << SECT_LSB);

    logic [7:0]       mem [DEPTH];
    logic [ARR_W-1:0] walk_ptr;
    logic [ARR_W:0]   walk_left;
    logic [ARR_W-1:0] sect_base;

    // Sector base: clear the in-sector offset bits, or whole array if one sector.
    generate
        if (SECT_LSB < ARR_W) begin : g_sect
            assign sect_base = {job_idx[ARR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
        end else begin : g_whole
            logic unused_idx;
            assign unused_idx = ^job_idx;
            assign sect_base  = '0;
        end
    endgenerate

    // Erase walker: pointer and remaining byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_ptr  <= '0;
            walk_left <= '0;
        end else if (chip_en) begin
            walk_ptr  <= '0;
            walk_left <= (ARR_W+1)'(DEPTH);
        end else if (sect_en) begin
            walk_ptr  <= sect_base;
            walk_left <= (ARR_W+1)'(SECT_SIZE);
        end else if (walk_left != '0) begin
            walk_ptr  <= walk_ptr + ARR_W'(1);
            walk_left <= walk_left - (ARR_W+1)'(1);
        end
    end

    // Storage update: program clears bits, walker sets bytes to all ones.
    always_ff @(posedge clk) begin
        if (pgm_en)                 mem[job_idx]  <= mem[job_idx] & pgm_byte;
        else if (walk_left != '0)   mem[walk_ptr] <= 8'hFF;
    end

    assign rd_byte   = mem[rd_idx];
    assign walk_busy = (walk_left != '0);
endmodule

// File: rtl/nor_cmd_ctrl.sv
// Top of the flash command interpreter: sequence decoder, busy timer,
// byte array with erase walker, and the registered read path that returns
// array bytes, identification bytes or write status. Assumes ADDR_W >= 15
// and ARR_W <= 15; reads and writes are single-cycle strobes.
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          ARR_W     = 10,
    parameter int          SECT_LSB  = 8,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 300,
    parameter logic [7:0]  MFR_ID    = 8'h5A,
    parameter logic [7:0]  DEV_ID    = 8'hC3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              busy
);
    localparam int LONGEST = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    job_t             job_w;
    seq_t             seq_state;
    logic             id_mode;
    logic             tmr_busy;
    logic             walk_busy;
    logic [7:0]       arr_byte;
    logic [CNT_W-1:0] tmr_len;
    logic             erase_q;
    logic             pbit7_q;
    logic             tog_q;

    // Address bits above the command width take part in nothing.
    generate
        if (ADDR_W > CMD_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^addr[ADDR_W-1:CMD_W];
        end
    endgenerate

    nor_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .busy_i    (busy),
        .cmd_addr  (addr[CMD_W-1:0]),
        .wdata     (wdata),
        .job_o     (job_w),
        .id_mode_o (id_mode),
        .state_o   (seq_state)
    );

    assign tmr_len = (job_w == JOB_PROG) ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);

    nor_busy_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (job_w != JOB_NONE),
        .len_i   (tmr_len),
        .busy_o  (tmr_busy)
    );

    nor_byte_array #(.ARR_W(ARR_W), .SECT_LSB(SECT_LSB)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pgm_en    (job_w == JOB_PROG),
        .chip_en   (job_w == JOB_CHIP),
        .sect_en   (job_w == JOB_SECT),
        .job_idx   (addr[ARR_W-1:0]),
        .pgm_byte  (wdata),
        .rd_idx    (addr[ARR_W-1:0]),
        .rd_byte   (arr_byte),
        .walk_busy (walk_busy)
    );

    assign busy = tmr_busy | walk_busy;

    // Read path plus status context: kind of job, data bit 7, toggle bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= 8'h00;
            erase_q <= 1'b0;
            pbit7_q <= 1'b0;
            tog_q   <= 1'b1;
        end else begin
            if (rd_en) begin
                if (busy) begin
                    rdata <= {(erase_q ? 1'b0 : ~pbit7_q), tog_q, 6'b0};
                    tog_q <= ~tog_q;
                end else if (id_mode) begin
                    rdata <= addr[0] ? DEV_ID : MFR_ID;
                end else begin
                    rdata <= arr_byte;
                end
            end
            if (job_w != JOB_NONE) begin
                erase_q <= (job_w != JOB_PROG);
                pbit7_q <= wdata[7];
                tog_q   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nor_cmd_ctrl_chk.sv
// Property checker for nor_cmd_ctrl, bound to every instance of it.
module nor_cmd_ctrl_chk
    import nor_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic       busy,
    input logic [7:0] rdata,
    input job_t       job,
    input seq_t       seq_state
);
    assert_job_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (job != JOB_NONE) |=> busy);

    assert_write_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> $stable(seq_state));

    assert_idle_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (seq_state == SQ_IDLE));

    assert_status_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy) |=> (rdata[5:0] == 6'd0));

    assert_first_toggle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(busy) && rd_en) |=> rdata[6]);

    assert_toggle_flips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rd_en && busy && $past(rd_en && busy)) |=> (rdata[6] != $past(rdata[6])));
endmodule

bind nor_cmd_ctrl nor_cmd_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .busy      (busy),
    .rdata     (rdata),
    .job       (job_w),
    .seq_state (seq_state)
);

// File: tb/nor_cmd_ctrl_tb.sv
module nor_cmd_ctrl_tb_top;
    localparam int         DEPTH  = 1024;
    localparam int         SECT   = 256;
    localparam int         PROG   = 8;
    localparam int         ERASE  = 300;
    localparam logic [7:0] MFR    = 8'h5A;
    localparam logic [7:0] DEV    = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en;
    logic [15:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  rdata;
    logic        busy;

    int          total = 0;
    int          bad   = 0;
    logic [7:0]  exp_mem [DEPTH];

    always #2 clk = ~clk;

    nor_cmd_ctrl #(
        .ADDR_W(16), .ARR_W(10), .SECT_LSB(8), .PROG_CYC(PROG),
        .ERASE_CYC(ERASE), .MFR_ID(MFR), .DEV_ID(DEV)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    function automatic logic [7:0] patt(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic unlock(input logic [15:0] hi);
        wr(hi | 16'h5555, 8'hAA);
        wr(hi | 16'h2AAA, 8'h55);
    endtask

    task automatic prog(input logic [15:0] hi, input logic [15:0] a, input logic [7:0] d);
        unlock(hi);
        wr(hi | 16'h5555, 8'hA0);
        wr(hi | a, d);
    endtask

    task automatic erase_pre(input logic [15:0] hi);
        unlock(hi);
        wr(hi | 16'h5555, 8'h80);
        unlock(hi);
    endtask

    task automatic count_busy(inout int n);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sweep(input string tag);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            rd(16'(a), v);
            chk(v == exp_mem[a], tag, v, exp_mem[a]);
        end
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata == 8'h00, "R1 rdata after reset", rdata, 0);
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);

        // Chip erase with bit 15 set on every command address.
        erase_pre(16'h8000);
        wr(16'hD555, 8'h10);
        n = 0;
        rd(16'h0000, v); n++;
        chk(v == 8'h40, "R7 R8 first erase status", v, 8'h40);
        rd(16'h0000, v); n++;
        chk(v == 8'h00, "R8 second erase status", v, 8'h00);
        count_busy(n);
        chk(n == DEPTH, "R3 chip erase busy length", n, DEPTH);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        sweep("R3 chip erase contents");

        // Program every byte; status checked for the first few.
        for (int a = 0; a < DEPTH; a++) begin
            logic [7:0] d;
            d = patt(a);
            prog((a % 2 == 1) ? 16'h8000 : 16'h0000, 16'(a), d);
            exp_mem[a] = exp_mem[a] & d;
            n = 0;
            if (a < 5) begin
                rd(16'(a), v); n++;
                chk(v == {~d[7], 1'b1, 6'b0}, "R7 R8 program status first", v, {~d[7], 1'b1, 6'b0});
                rd(16'(a), v); n++;
                chk(v == {~d[7], 1'b0, 6'b0}, "R7 R8 program status second", v, {~d[7], 1'b0, 6'b0});
            end
            count_busy(n);
            if (a < 5) chk(n == PROG, "R5 program busy length", n, PROG);
        end
        sweep("R2 R12 program contents");

        // Bits only clear on a second program.
        prog(16'h0000, 16'h0005, 8'h0F);
        exp_mem[5] = exp_mem[5] & 8'h0F;
        n = 0; count_busy(n);
        rd(16'h0005, v);
        chk(v == exp_mem[5], "R2 reprogram ANDs", v, exp_mem[5]);

        // Broken program sequence.
        wr(16'h5555, 8'hAA);
        wr(16'h2AAB, 8'h55);
        wr(16'h5555, 8'hA0);
        wr(16'h0010, 8'h00);
        chk(busy == 1'b0, "R6 broken program no busy", busy, 0);
        rd(16'h0010, v);
        chk(v == exp_mem[16], "R6 broken program no change", v, exp_mem[16]);
        // Broken erase sequence (bad final code).
        erase_pre(16'h0000);
        wr(16'h5555, 8'h20);
        chk(busy == 1'b0, "R6 broken erase no busy", busy, 0);
        rd(16'h0020, v);
        chk(v == exp_mem[32], "R6 broken erase no change", v, exp_mem[32]);

        // Sector erase of sector 2 with writes issued while busy.
        erase_pre(16'h0000);
        wr(16'hF234, 8'h30);
        n = 0;
        rd(16'h0000, v); n++;
        chk(v == 8'h40, "R7 R8 sector status first", v, 8'h40);
        rd(16'h0000, v); n++;
        chk(v == 8'h00, "R8 sector status second", v, 8'h00);
        prog(16'h0000, 16'h0010, 8'h00); n += 4;
        wr(16'h1234, 8'hF0); n++;
        count_busy(n);
        chk(n == ERASE, "R4 sector erase busy length", n, ERASE);
        for (int a = 512; a < 768; a++) exp_mem[a] = 8'hFF;
        sweep("R4 R9 sector erase contents");

        // Identification mode.
        unlock(16'h0000);
        wr(16'h5555, 8'h90);
        rd(16'h0000, v);
        chk(v == MFR, "R10 manufacturer byte", v, MFR);
        rd(16'h0001, v);
        chk(v == DEV, "R10 device byte", v, DEV);
        rd(16'h0402, v);
        chk(v == MFR, "R10 bit0 selects", v, MFR);
        prog(16'h0000, 16'h0300, 8'h3C);
        exp_mem[768] = exp_mem[768] & 8'h3C;
        wr(16'h1234, 8'hF0);
        n = 0; count_busy(n);
        rd(16'h0001, v);
        chk(v == DEV, "R9 exit ignored while busy", v, DEV);
        wr(16'h7777, 8'hF0);
        rd(16'h0300, v);
        chk(v == exp_mem[768], "R11 single-write exit", v, exp_mem[768]);
        unlock(16'h0000);
        wr(16'h5555, 8'h90);
        rd(16'h0001, v);
        chk(v == DEV, "R10 re-entry", v, DEV);
        unlock(16'h0000);
        wr(16'h5555, 8'hF0);
        rd(16'h0001, v);
        chk(v == exp_mem[1], "R11 three-write exit", v, exp_mem[1]);

        // Program of an erased byte with bit 7 set, then true data.
        prog(16'h0000, 16'h0205, 8'h80);
        rd(16'h0205, v);
        chk(v == 8'h40, "R7 status bit7 inverted", v, 8'h40);
        n = 0; count_busy(n);
        rd(16'h0205, v);
        chk(v == 8'h80, "R7 true data after busy", v, 8'h80);
        rd(16'h0000, v);
        repeat (2) @(negedge clk);
        chk(rdata == v, "R12 rdata holds without read", rdata, v);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule